// File: doc/BRIEF.md
# Serial (7,4) Cyclic Code Encoder

This block turns a 4-bit information word into a 7-bit systematic cyclic codeword and sends it out one bit per clock. A load strobe captures the word. Starting in the next cycle, the block sends the four information bits, most significant first. It then sends three check bits: the remainder of x^3·m(x) divided by g(x) = x^3 + x + 1, highest-order coefficient first. A one-cycle completion pulse marks the last bit of the codeword.

Internally, a parallel-load register pads the word with three zero bits and shifts it right. A three-stage divider register built from flip-flops and XOR gates computes the remainder from the serial bits. A position counter steers the output selector between the data stream and the remainder. After the seventh bit the counter parks in an idle state, where the output is held at 0 until the next load. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `cyclic_enc74`

## Requirements
- R1: While `rst_n` is low, and from the end of reset until the first load, `code_bit` and `word_done` are 0.
- R2: In the 4 cycles after a load edge, `code_bit` carries `info[3]`, `info[2]`, `info[1]`, `info[0]` in that order.
- R3: In cycles 5 to 7 after a load edge, `code_bit` carries the remainder of `info`·x^3 divided by x^3+x+1, with the x^2 coefficient first and the x^0 coefficient last.
- R4: The 7 bits sent after a load, read first bit as the highest power, form a polynomial that x^3+x+1 divides exactly.
- R5: `word_done` is high for exactly one cycle per codeword: the cycle in which the seventh bit is on `code_bit`.
- R6: Once a codeword is complete, `code_bit` and `word_done` stay 0 until the next load.
- R7: A load during a codeword abandons it. The next cycle starts the new word from its first bit, and its check bits are unaffected by the abandoned word.
- R8: While `load` is held high, each edge restarts the word: `code_bit` stays at `info[3]` and `word_done` stays 0.
- R9: Asserting `rst_n` low mid-word forces `code_bit` and `word_done` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Captures `info` and restarts the codeword |
| info | input | 4 | Information word, bit 3 sent first |
| code_bit | output | 1 | Serial codeword bit |
| word_done | output | 1 | High while the last codeword bit is on `code_bit` |

## Verification
After the load edge, the first information bit appears on `code_bit` within that same cycle, because the output is taken straight from registers. Bit j of the codeword is therefore due j cycles after the first. `word_done` is due with bit 6, and the idle zero follows one cycle later. The bench drives `load` on falling edges and samples once per cycle on the falling edge. Its position index counts up from the cycle after the load edge, so each compare falls at the cycle in which its bit is due. The expected check bits come from a long division by 1011 done in the bench, repeated for all 16 words, for a restart mid-word, and for a held load.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
  // Position phase of the serial word
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INFO  = 2'd1,
    PH_CHECK = 2'd2
  } cenc_phase_e;
endpackage

// File: rtl/cenc_rst_sync.sv
module cenc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/cenc_seqctl.sv
module cenc_seqctl
  import cenc_pkg::*;
#(
  parameter int K = 4,
  parameter int R = 3,
  localparam int N = K + R,
  localparam int CW = $clog2(N + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  output cenc_phase_e phase,
  output logic        done
);
  localparam logic [CW-1:0] IDLE_CNT = CW'(N);
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);
  localparam logic [CW-1:0] INFO_END = CW'(K);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != IDLE_CNT);
    if (load)                  cnt_d = '0;
    else if (cnt_q == LAST_CNT) cnt_d = IDLE_CNT;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= IDLE_CNT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    if (cnt_q < INFO_END)      phase = PH_INFO;
    else if (cnt_q < IDLE_CNT) phase = PH_CHECK;
    else                       phase = PH_IDLE;
  end

  assign done = (cnt_q == LAST_CNT);
endmodule

// File: rtl/cenc_shreg.sv
module cenc_shreg #(
  parameter int K = 4,
  parameter int R = 3,
  localparam int N = K + R
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift_en,
  input  logic [K-1:0] info,
  output logic         ser
);
  logic [N-1:0] sr_q;
  logic [N-1:0] sr_d;
  logic [N-1:0] load_val;
  logic         sr_en;

  // Bit 0 leaves first, so the word's top bit sits there; zero padding above.
  for (genvar i = 0; i < N; i++) begin : g_pad
    if (i < K) begin : g_info
      assign load_val[i] = info[K-1-i];
    end else begin : g_zero
      assign load_val[i] = 1'b0;
    end
  end

  always_comb begin
    sr_en = load || shift_en;
    sr_d  = load ? load_val : {1'b0, sr_q[N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign ser = sr_q[0];
endmodule

// File: rtl/cenc_remgen.sv
module cenc_remgen
  import cenc_pkg::*;
#(
  parameter int R = 3,
  parameter logic [R-1:0] POLY_LOW = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  cenc_phase_e phase,
  input  logic        din,
  output logic        rem_msb
);
  logic [R-1:0] g_q;
  logic [R-1:0] g_d;
  logic         fb;
  logic         g_en;

  // Feedback only while information bits enter; during check phase it is a plain shift.
  assign fb   = (phase == PH_INFO) ? (din ^ g_q[R-1]) : 1'b0;
  assign g_en = clr || (phase != PH_IDLE);

  for (genvar i = 0; i < R; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign g_d[i] = clr ? 1'b0 : (POLY_LOW[i] & fb);
    end else begin : g_rest
      assign g_d[i] = clr ? 1'b0 : (g_q[i-1] ^ (POLY_LOW[i] & fb));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    g_q <= '0;
    else if (g_en) g_q <= g_d;
  end

  assign rem_msb = g_q[R-1];
endmodule

// File: rtl/cyclic_enc74.sv
module cyclic_enc74
  import cenc_pkg::*;
#(
  parameter int K = 4,
  parameter int R = 3,
  parameter logic [R-1:0] POLY_LOW = 3'b011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [K-1:0] info,
  output logic         code_bit,
  output logic         word_done
);
  logic        rst_q_n;
  cenc_phase_e phase;
  logic        done;
  logic        ser;
  logic        rem_msb;
  logic        shift_en;

  cenc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cenc_seqctl #(.K(K), .R(R)) u_seq (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load  (load),
    .phase (phase),
    .done  (done)
  );

  assign shift_en = (phase != PH_IDLE);

  cenc_shreg #(.K(K), .R(R)) u_sr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .shift_en (shift_en),
    .info     (info),
    .ser      (ser)
  );

  cenc_remgen #(.R(R), .POLY_LOW(POLY_LOW)) u_rem (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (load),
    .phase   (phase),
    .din     (ser),
    .rem_msb (rem_msb)
  );

  always_comb begin
    unique case (phase)
      PH_INFO:  code_bit = ser;
      PH_CHECK: code_bit = rem_msb;
      default:  code_bit = 1'b0;
    endcase
  end

  assign word_done = done;
endmodule

// File: rtl/cyclic_enc74_chk.sv
module cyclic_enc74_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       load,
  input logic       code_bit,
  input logic       word_done,
  input logic [2:0] cnt,
  input logic [2:0] gen
);
  // R7: a load always restarts at the first position
  a_r7_load_restart: assert property (@(posedge clk) disable iff (!rst_q_n)
    load |=> (cnt == 3'd0));

  // R2: positions advance one per clock without a load
  a_r2_count_advance: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!load && cnt < 3'd6) |=> (cnt == $past(cnt) + 3'd1));

  // R5: the done pulse never lasts two cycles
  a_r5_done_one_wide: assert property (@(posedge clk) disable iff (!rst_q_n)
    word_done |=> !word_done);

  // R6: after the last bit the block idles and stays quiet
  a_r6_park_after_last: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt == 3'd6 && !load) |=> (cnt == 3'd7));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt == 3'd7) |-> (!code_bit && !word_done));

  // R3: check bits leave as a plain shift with no feedback
  a_r3_flush_shift: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!load && (cnt == 3'd4 || cnt == 3'd5)) |=> (gen[2] == $past(gen[1]) && gen[1] == $past(gen[0]) && !gen[0]));
endmodule

bind cyclic_enc74 cyclic_enc74_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .load      (load),
  .code_bit  (code_bit),
  .word_done (word_done),
  .cnt       (u_seq.cnt_q),
  .gen       (u_rem.g_q)
);

// File: tb/cyclic_enc74_bench.sv
module cyclic_enc74_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] info = 4'd0;
  logic       code_bit;
  logic       word_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  cyclic_enc74 u_cyclic_enc74 (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .info      (info),
    .code_bit  (code_bit),
    .word_done (word_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] codeword(input logic [3:0] m);
    logic [6:0] c;
    c = {m, 3'b000};
    for (int i = 6; i >= 3; i--) begin
      if (c[i]) c = c ^ (7'b0001011 << (i - 3));
    end
    return {m, c[2:0]};
  endfunction

  function automatic logic [2:0] poly_mod(input logic [6:0] v);
    logic [6:0] c;
    c = v;
    for (int i = 6; i >= 3; i--) begin
      if (c[i]) c = c ^ (7'b0001011 << (i - 3));
    end
    return c[2:0];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Loads w on the next edge; returns at the negedge where bit 0 is due.
  task automatic start_word(input logic [3:0] w);
    @(negedge clk);
    load = 1'b1;
    info = w;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_word(input logic [3:0] w, input bit check_idle);
    logic [6:0] cw;
    logic [6:0] got;
    cw = codeword(w);
    for (int j = 0; j < 7; j++) begin
      if (j > 0) @(negedge clk);
      got[6-j] = code_bit;
      if (j < 4) check("R2", code_bit, cw[6-j]);
      else       check("R3", code_bit, cw[6-j]);
      check("R5", word_done, (j == 6));
    end
    checks++;
    if (poly_mod(got) !== 3'b000) begin
      failures++;
      $display("FAIL R4: actual=%b expected=000 word=%b", poly_mod(got), got);
    end
    if (check_idle) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R6", code_bit, 1'b0);
        check("R6", word_done, 1'b0);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1", code_bit, 1'b0);
    check("R1", word_done, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", code_bit, 1'b0);
    check("R1", word_done, 1'b0);

    // All 16 words
    for (int w = 0; w < 16; w++) begin
      start_word(4'(w));
      run_word(4'(w), 1'b1);
    end

    // R7: abandon word 1111 after 3 bits, restart with 0110
    start_word(4'b1111);
    repeat (2) @(negedge clk);
    load = 1'b1;
    info = 4'b0110;
    @(negedge clk);
    load = 1'b0;
    run_word(4'b0110, 1'b1);
    check("R7", code_bit, 1'b0);

    // R7: restart during check phase
    start_word(4'b1011);
    repeat (5) @(negedge clk);
    load = 1'b1;
    info = 4'b1001;
    @(negedge clk);
    load = 1'b0;
    run_word(4'b1001, 1'b1);

    // R8: load held high
    @(negedge clk);
    load = 1'b1;
    info = 4'b1010;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      check("R8", code_bit, 1'b1);
      check("R8", word_done, 1'b0);
    end
    load = 1'b0;
    run_word(4'b1010, 1'b1);

    // R9: asynchronous reset mid-word
    start_word(4'b1101);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R9", code_bit, 1'b0);
    check("R9", word_done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", code_bit, 1'b0);
    start_word(4'b1101);
    run_word(4'b1101, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule